// File: doc/BRIEF.md
# OUT Endpoint Transfer Progress Tracker

This block follows one receive-direction endpoint transfer inside a USB device controller. Software starts a transfer with one write to a size word. The word holds three fields: the transfer length in bytes, the number of packets expected, and, for control endpoints, how many back-to-back SETUP packets may still be taken. After that write the block marks the transfer active.

Two event streams move the counters. A FIFO-write pulse means a packet from the bus has landed in the receive FIFO. It lowers the packet counter or, when the packet is a SETUP packet, the SETUP allowance. A drain pulse means a packet has left the FIFO for memory. Its byte length comes with it and is subtracted from the byte counter.

The transfer finishes when the byte counter reaches zero or when a short packet is drained. The block then raises a sticky completion flag that serves as the interrupt, and drops the active flag. Counters never wrap: a decrement at zero sets a sticky error flag, and a SETUP packet beyond the allowance sets a sticky overflow flag.

Top module: `out_xfer_tracker`

## Requirements
- R1: After reset, all three counters read zero, and the done, error, overflow and active flags are all low.
- R2: A pulse on `cfg_wr` loads three fields from `cfg_wdata`, visible after the next rising edge. The byte size comes from bits 18:0 and the packet count from bits 28:19. The SETUP allowance comes from bits 30:29, but only when `ep_is_ctrl` is high; otherwise it loads 0. The same load clears done, error and overflow and sets active.
- R3: A `rx_wr` pulse with `rx_wr_setup` low lowers `pkt_cnt` by one, whether the packet is full or short.
- R4: A `rx_drain` pulse lowers `xfer_size` by `rx_drain_len`.
- R5: While active, a drain that brings `xfer_size` to zero sets `xfer_done` and clears `xfer_active`. With the size programmed equal to `ep_mps`, every full packet ends the transfer.
- R6: While active, a drain with `rx_drain_len` below `ep_mps` sets `xfer_done` and clears `xfer_active`, and `xfer_size` keeps the remaining bytes.
- R7: `xfer_done` stays set until the next `cfg_wr`. A drain while inactive raises no new completion.
- R8: A `rx_wr` pulse with `rx_wr_setup` high lowers `setup_cnt` by one and leaves `pkt_cnt` unchanged. The allowance encoding is 1, 2 or 3 packets for values 01, 10 and 11.
- R9: A SETUP packet arriving when `setup_cnt` is 0 sets sticky `setup_ovf`, and `setup_cnt` stays 0.
- R10: A packet write when `pkt_cnt` is 0 leaves it at 0 and sets sticky `cnt_err`. A drain longer than `xfer_size` leaves `xfer_size` at 0 and sets `cnt_err`.
- R11: When `cfg_wr` arrives in the same cycle as packet events, the load wins and those events have no effect.
- R12: A FIFO write and a drain in the same cycle both take effect on their own counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_is_ctrl | input | 1 | Endpoint is a control endpoint |
| ep_mps | input | 11 | Maximum packet size in bytes |
| cfg_wr | input | 1 | Size-word write strobe |
| cfg_wdata | input | 31 | Size word: SETUP allowance, packet count, byte size |
| rx_wr | input | 1 | Packet written into receive FIFO |
| rx_wr_setup | input | 1 | Written packet is a SETUP packet |
| rx_drain | input | 1 | Packet drained from FIFO to memory |
| rx_drain_len | input | 11 | Byte length of the drained packet |
| xfer_size | output | 19 | Remaining bytes |
| pkt_cnt | output | 10 | Remaining packets |
| setup_cnt | output | 2 | Remaining SETUP allowance |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Transfer-complete interrupt, sticky |
| cnt_err | output | 1 | Counter underflow, sticky |
| setup_ovf | output | 1 | SETUP allowance exceeded, sticky |

## Verification
Directed sequences cover the two ways a transfer can end. A full-size drain that empties the byte count is kept apart from a short drain that leaves bytes behind. A size equal to the packet size confirms that completion follows every packet. Further sequences drive a SETUP burst through 3, 2, 1, 0 and on into overflow, and drive both counters into saturation. They also put a reload in the same cycle as packet events, which shows the load winning over a concurrent decrement. Random stretches mix writes, SETUP writes, drains and reloads with varied packet sizes, so that simultaneous write-and-drain cycles and long and short drains show up in every combination.

// File: rtl/out_xfer_pkg.sv
package out_xfer_pkg;
  localparam int SIZE_W_DEF  = 19;
  localparam int PKT_W_DEF   = 10;
  localparam int SETUP_W_DEF = 2;
  localparam int LEN_W_DEF   = 11;

  typedef struct packed {
    logic done;
    logic err;
    logic ovf;
    logic active;
  } xt_flags_t;
endpackage

// File: rtl/xt_sat_dec.sv
module xt_sat_dec #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         uf_evt
);
  function automatic logic [W-1:0] step_down(input logic [W-1:0] c);
    return (c == '0) ? '0 : c - W'(1);
  endfunction

  assign uf_evt = dec & ~load & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= step_down(cnt);
  end
endmodule

// File: rtl/xt_byte_ctr.sv
module xt_byte_ctr #(
  parameter int SIZE_W = 19,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] load_val,
  input  logic              drain,
  input  logic [LEN_W-1:0]  len,
  input  logic [LEN_W-1:0]  mps,
  input  logic              active,
  output logic [SIZE_W-1:0] size,
  output logic              uf_evt,
  output logic              done_evt
);
  function automatic logic [SIZE_W-1:0] remain(input logic [SIZE_W-1:0] s,
                                                input logic [LEN_W-1:0]  l);
    logic [SIZE_W-1:0] lx;
    lx = SIZE_W'(l);
    return (lx > s) ? '0 : s - lx;
  endfunction

  function automatic logic is_short(input logic [LEN_W-1:0] l,
                                    input logic [LEN_W-1:0] m);
    return l < m;
  endfunction

  logic [SIZE_W-1:0] nxt;
  assign nxt      = remain(size, len);
  assign uf_evt   = drain & ~load & (SIZE_W'(len) > size);
  assign done_evt = drain & ~load & active & ((nxt == '0) | is_short(len, mps));

  always_ff @(posedge clk) begin
    if (!rst_n)      size <= '0;
    else if (load)   size <= load_val;
    else if (drain)  size <= nxt;
  end
endmodule

// File: rtl/out_xfer_tracker.sv
module out_xfer_tracker #(
  parameter int SIZE_W  = out_xfer_pkg::SIZE_W_DEF,
  parameter int PKT_W   = out_xfer_pkg::PKT_W_DEF,
  parameter int SETUP_W = out_xfer_pkg::SETUP_W_DEF,
  parameter int LEN_W   = out_xfer_pkg::LEN_W_DEF
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ep_is_ctrl,
  input  logic [LEN_W-1:0]                  ep_mps,
  input  logic                              cfg_wr,
  input  logic [SIZE_W+PKT_W+SETUP_W-1:0]   cfg_wdata,
  input  logic                              rx_wr,
  input  logic                              rx_wr_setup,
  input  logic                              rx_drain,
  input  logic [LEN_W-1:0]                  rx_drain_len,
  output logic [SIZE_W-1:0]                 xfer_size,
  output logic [PKT_W-1:0]                  pkt_cnt,
  output logic [SETUP_W-1:0]                setup_cnt,
  output logic                              xfer_active,
  output logic                              xfer_done,
  output logic                              cnt_err,
  output logic                              setup_ovf
);
  import out_xfer_pkg::*;

  localparam int PKT_LO   = SIZE_W;
  localparam int SETUP_LO = SIZE_W + PKT_W;
  localparam int CFG_W    = SIZE_W + PKT_W + SETUP_W;

  logic [SIZE_W-1:0]  ld_size;
  logic [PKT_W-1:0]   ld_pkt;
  logic [SETUP_W-1:0] ld_setup;
  logic               pkt_dec, setup_dec;
  logic               pkt_uf, setup_uf, byte_uf, done_evt;
  xt_flags_t          flags;

  assign ld_size   = cfg_wdata[SIZE_W-1:0];
  assign ld_pkt    = cfg_wdata[PKT_LO +: PKT_W];
  assign ld_setup  = ep_is_ctrl ? cfg_wdata[SETUP_LO +: SETUP_W] : '0;
  assign pkt_dec   = rx_wr & ~rx_wr_setup;
  assign setup_dec = rx_wr &  rx_wr_setup;

  xt_sat_dec #(.W(PKT_W)) u_pkt (
    .clk(clk), .rst_n(rst_n), .load(cfg_wr), .load_val(ld_pkt),
    .dec(pkt_dec), .cnt(pkt_cnt), .uf_evt(pkt_uf)
  );

  xt_sat_dec #(.W(SETUP_W)) u_setup (
    .clk(clk), .rst_n(rst_n), .load(cfg_wr), .load_val(ld_setup),
    .dec(setup_dec), .cnt(setup_cnt), .uf_evt(setup_uf)
  );

  xt_byte_ctr #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .load(cfg_wr), .load_val(ld_size),
    .drain(rx_drain), .len(rx_drain_len), .mps(ep_mps),
    .active(flags.active), .size(xfer_size), .uf_evt(byte_uf),
    .done_evt(done_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (cfg_wr) begin
      flags <= '{done: 1'b0, err: 1'b0, ovf: 1'b0, active: 1'b1};
    end else begin
      if (done_evt) begin
        flags.done   <= 1'b1;
        flags.active <= 1'b0;
      end
      if (pkt_uf | byte_uf) flags.err <= 1'b1;
      if (setup_uf)         flags.ovf <= 1'b1;
    end
  end

  assign xfer_active = flags.active;
  assign xfer_done   = flags.done;
  assign cnt_err     = flags.err;
  assign setup_ovf   = flags.ovf;

  if (CFG_W < 3) begin : g_bad_cfg
    initial $error("size word too narrow");
  end
endmodule

// File: rtl/out_xfer_tracker_chk.sv
module out_xfer_tracker_chk #(
  parameter int SIZE_W  = 19,
  parameter int PKT_W   = 10,
  parameter int SETUP_W = 2,
  parameter int LEN_W   = 11
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cfg_wr,
  input logic [SIZE_W+PKT_W+SETUP_W-1:0] cfg_wdata,
  input logic                            rx_wr,
  input logic                            rx_wr_setup,
  input logic                            rx_drain,
  input logic [LEN_W-1:0]                rx_drain_len,
  input logic [SIZE_W-1:0]               xfer_size,
  input logic [PKT_W-1:0]                pkt_cnt,
  input logic [SETUP_W-1:0]              setup_cnt,
  input logic                            xfer_active,
  input logic                            xfer_done,
  input logic                            cnt_err,
  input logic                            setup_ovf
);
  AST_LOAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (xfer_size == $past(cfg_wdata[SIZE_W-1:0])) && !xfer_done && xfer_active); // R2

  AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr && !rx_wr_setup && !cfg_wr && pkt_cnt != '0) |=> pkt_cnt == $past(pkt_cnt) - PKT_W'(1)); // R3

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drain && !cfg_wr && SIZE_W'(rx_drain_len) <= xfer_size)
      |=> xfer_size == $past(xfer_size) - SIZE_W'($past(rx_drain_len))); // R4

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cfg_wr) |=> xfer_done && !xfer_active); // R7

  AST_SETUP_KEEP_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr && rx_wr_setup && !cfg_wr) |=> $stable(pkt_cnt)); // R8

  AST_NO_SETUP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr && rx_wr_setup && !cfg_wr && setup_cnt == '0) |=> setup_ovf && setup_cnt == '0); // R9

  AST_PKT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr && !rx_wr_setup && !cfg_wr && pkt_cnt == '0) |=> cnt_err && pkt_cnt == '0); // R10
endmodule

bind out_xfer_tracker out_xfer_tracker_chk #(
  .SIZE_W(SIZE_W), .PKT_W(PKT_W), .SETUP_W(SETUP_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .rx_wr(rx_wr), .rx_wr_setup(rx_wr_setup), .rx_drain(rx_drain),
  .rx_drain_len(rx_drain_len), .xfer_size(xfer_size), .pkt_cnt(pkt_cnt),
  .setup_cnt(setup_cnt), .xfer_active(xfer_active), .xfer_done(xfer_done),
  .cnt_err(cnt_err), .setup_ovf(setup_ovf)
);

// File: tb/out_xfer_tracker_tb.sv
`timescale 1ns/1ps
module out_xfer_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ep_is_ctrl = 1'b1;
  logic [10:0] ep_mps = 11'd64;
  logic        cfg_wr = 1'b0;
  logic [30:0] cfg_wdata = '0;
  logic        rx_wr = 1'b0, rx_wr_setup = 1'b0, rx_drain = 1'b0;
  logic [10:0] rx_drain_len = '0;
  logic [18:0] xfer_size;
  logic [9:0]  pkt_cnt;
  logic [1:0]  setup_cnt;
  logic        xfer_active, xfer_done, cnt_err, setup_ovf;

  int n_chk = 0, n_bad = 0;
  int m_size, m_pkt, m_setup;
  bit m_act, m_done, m_err, m_ovf;

  always #10 clk = ~clk;

  out_xfer_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .ep_is_ctrl(ep_is_ctrl), .ep_mps(ep_mps),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .rx_wr(rx_wr),
    .rx_wr_setup(rx_wr_setup), .rx_drain(rx_drain), .rx_drain_len(rx_drain_len),
    .xfer_size(xfer_size), .pkt_cnt(pkt_cnt), .setup_cnt(setup_cnt),
    .xfer_active(xfer_active), .xfer_done(xfer_done), .cnt_err(cnt_err),
    .setup_ovf(setup_ovf)
  );

  function automatic logic [30:0] pack(int sz, int pk, int su);
    logic [30:0] w;
    w = '0;
    w[18:0]  = sz[18:0];
    w[28:19] = pk[9:0];
    w[30:29] = su[1:0];
    return w;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "xfer_size", int'(xfer_size), m_size);
    chk(tag, "pkt_cnt", int'(pkt_cnt), m_pkt);
    chk(tag, "setup_cnt", int'(setup_cnt), m_setup);
    chk(tag, "active", int'(xfer_active), int'(m_act));
    chk(tag, "done", int'(xfer_done), int'(m_done));
    chk(tag, "err", int'(cnt_err), int'(m_err));
    chk(tag, "ovf", int'(setup_ovf), int'(m_ovf));
  endtask

  // Reference update, from the requirements
  task automatic model(bit c, int sz, int pk, int su, bit w, bit s, bit d, int len);
    int mps;
    mps = int'(ep_mps);
    if (c) begin
      m_size = sz; m_pkt = pk; m_setup = ep_is_ctrl ? su : 0;
      m_done = 0; m_err = 0; m_ovf = 0; m_act = 1;
      return;
    end
    if (w && !s) begin if (m_pkt == 0) m_err = 1; else m_pkt--; end
    if (w && s)  begin if (m_setup == 0) m_ovf = 1; else m_setup--; end
    if (d) begin
      if (len > m_size) begin m_err = 1; m_size = 0; end
      else m_size -= len;
      if (m_act && (m_size == 0 || len < mps)) begin m_done = 1; m_act = 0; end
    end
  endtask

  // Called at a negedge; returns at the following negedge after checking
  task automatic step(string tag, bit c, int sz, int pk, int su,
                      bit w, bit s, bit d, int len);
    cfg_wr = c; cfg_wdata = pack(sz, pk, su);
    rx_wr = w; rx_wr_setup = s; rx_drain = d; rx_drain_len = len[10:0];
    @(posedge clk);
    model(c, sz, pk, su, w, s, d, len);
    @(negedge clk);
    chk_all(tag);
    cfg_wr = 0; rx_wr = 0; rx_wr_setup = 0; rx_drain = 0; rx_drain_len = '0;
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd7041);
    m_size = 0; m_pkt = 0; m_setup = 0;
    m_act = 0; m_done = 0; m_err = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");

    // R2 load on a control endpoint, R3 packet write, R8 SETUP writes
    step("R2 load", 1, 256, 4, 3, 0, 0, 0, 0);
    step("R3 pkt write", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R8 setup write", 0, 0, 0, 0, 1, 1, 0, 0);
    step("R8 setup write", 0, 0, 0, 0, 1, 1, 0, 0);
    step("R8 setup write", 0, 0, 0, 0, 1, 1, 0, 0);
    step("R9 setup overflow", 0, 0, 0, 0, 1, 1, 0, 0);
    // R4 full drain, R12 write and drain together
    step("R4 drain", 0, 0, 0, 0, 0, 0, 1, 64);
    step("R12 write+drain", 0, 0, 0, 0, 1, 0, 1, 64);
    // R6 short drain ends early, R7 done sticky
    step("R6 short drain", 0, 0, 0, 0, 0, 0, 1, 10);
    step("R7 drain after done", 0, 0, 0, 0, 0, 0, 1, 64);
    step("R7 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    // R11 load wins over same-cycle events
    step("R11 load with events", 1, 500, 7, 2, 1, 0, 1, 20);
    step("R11 load with setup", 1, 300, 5, 1, 1, 1, 0, 0);
    // R2 non-control endpoint loads no SETUP allowance
    ep_is_ctrl = 0;
    step("R2 non-ctrl load", 1, 128, 2, 3, 0, 0, 0, 0);
    step("R9 setup on non-ctrl", 0, 0, 0, 0, 1, 1, 0, 0);
    ep_is_ctrl = 1;
    // R5 size equal to packet size: done after every packet
    for (int k = 0; k < 3; k++) begin
      step("R5 per-packet load", 1, 64, 1, 0, 0, 0, 0, 0);
      step("R5 per-packet drain", 0, 0, 0, 0, 1, 0, 1, 64);
    end
    // R10 saturation of both counters
    step("R10 load", 1, 30, 1, 0, 0, 0, 0, 0);
    step("R10 pkt to zero", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R10 pkt underflow", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R10 load", 1, 30, 1, 0, 0, 0, 0, 0);
    ep_mps = 11'd16;
    step("R10 byte underflow", 0, 0, 0, 0, 0, 0, 1, 40);

    // Random mix: R3 R4 R12 with reloads
    for (int i = 0; i < 600; i++) begin
      int op, len;
      op = int'($urandom_range(0, 19));
      if (op == 0) begin
        ep_mps = 11'($urandom_range(8, 64));
        step("R2 random reload", 1, int'($urandom_range(0, 2000)),
             int'($urandom_range(0, 20)), int'($urandom_range(0, 3)), 0, 0, 0, 0);
      end else begin
        len = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 80)) : int'(ep_mps);
        step("R3 R4 R12 random", 0, 0, 0, 0,
             1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0),
             1'($urandom_range(0, 1)), len);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule